// File: doc/BRIEF.md
# UART Receive Character Match Filter

This block sits between the character output of a UART receiver and the receive data buffer. For each character the receiver delivers, it decides whether the character goes on to the buffer or is thrown away. When no match compare is enabled, every character goes through. With compares enabled, forwarding is controlled by a window that holds state from one character to the next.

Two filtering schemes are provided. In the idle-line scheme, the first character after an idle line acts as an address. It is compared against one or both match values. On a hit, that character and everything up to the next idle line are forwarded. On a miss, the whole message is dropped. In the open/close scheme, a character equal to the first match value opens forwarding. A character equal to the second match value closes it, and that closing character is itself dropped.

A receive-data-full flag rises with each forwarded character and stays up until software pulses a clear input.

Top module: `uart_rx_match_filter`

## Requirements
- R1: With both match enables low, every received character is forwarded, whatever the mode select holds. `fwd_vld` is high for exactly one cycle, on the cycle after `char_vld`, and `fwd_data` equals the received byte.
- R2: Mode select 2'b01 chooses the idle-line scheme. Mode select 2'b10 chooses the open/close scheme, but only when both enables are high. Values 2'b00 and 2'b11, and 2'b10 with only one enable high, pass every character through.
- R3: Idle-line scheme, hit case. When the first character after an idle pulse equals an enabled match value, that character and every later character before the next idle pulse are forwarded.
- R4: Idle-line scheme, miss case. When the first character after an idle pulse matches no enabled value, it is dropped, and so is every later character until the next idle pulse.
- R5: With a single enable high, the first character is compared only with that enable's own match value. A character equal to the disabled value is treated as a miss.
- R6: With both enables high in the idle-line scheme, a first character equal to either match value opens the window.
- R7: Open/close scheme. While closed, a character equal to match value 1 is forwarded and opens the window. While open, every character that is not equal to match value 2 is forwarded.
- R8: Open/close scheme. A character equal to match value 2 while open is dropped and closes the window. Characters stay dropped until a character equal to match value 1 arrives.
- R9: After reset the window is closed in both schemes. Idle-line scheme: characters before the first idle pulse are dropped. Open/close scheme: characters are dropped until a match value 1 character arrives.
- R10: An idle pulse in the same cycle as a character is applied first. That character is therefore judged as the first character after an idle line.
- R11: `rx_full` goes high in the same cycle as every `fwd_vld`. A one-cycle `full_clr` pulse lowers it on the next cycle. When a forward and a clear coincide, `rx_full` stays high. Dropped characters leave `rx_full` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| char_vld | input | 1 | Received character strobe |
| char_data | input | DATA_W | Received character |
| idle_det | input | 1 | One-cycle idle-line detect pulse |
| match_en1 | input | 1 | Enable for match value 1 |
| match_en2 | input | 1 | Enable for match value 2 |
| mode_sel | input | 2 | Filter scheme select (01 idle-line, 10 open/close) |
| match_val1 | input | DATA_W | Match value 1 |
| match_val2 | input | DATA_W | Match value 2 |
| full_clr | input | 1 | One-cycle clear of the receive-data-full flag |
| fwd_vld | output | 1 | Forwarded character strobe |
| fwd_data | output | DATA_W | Forwarded character |
| rx_full | output | 1 | Receive-data-full flag |

## Verification
Every result is registered once. `fwd_vld`, `fwd_data` and the rise of `rx_full` appear on the cycle after the character strobe. The fall of `rx_full` appears on the cycle after the clear pulse. The bench drives each stimulus just after a falling edge and holds it across one rising edge. It samples the outputs at the following falling edge, exactly one register stage later, and only then removes the strobe. Window state is observed only through whether later characters come out.

// File: rtl/rxm_pkg.sv
// Package rxm_pkg
// Shared types and the mode decode used by the receive match filter.
// Assumes the select encoding: 2'b01 idle-line scheme, 2'b10 open/close.
package rxm_pkg;

    localparam logic [1:0] SEL_IDLE  = 2'b01;
    localparam logic [1:0] SEL_ONOFF = 2'b10;

    typedef enum logic [1:0] {
        FMODE_PASS  = 2'd0,
        FMODE_IDLE  = 2'd1,
        FMODE_ONOFF = 2'd2
    } filt_mode_e;

    // Resolve enables and select into the active filter scheme.
    function automatic filt_mode_e decode_mode(input logic en1, input logic en2,
                                               input logic [1:0] sel);
        filt_mode_e m;
        m = FMODE_PASS;
        if (en1 || en2) begin
            if (sel == SEL_IDLE)
                m = FMODE_IDLE;
            else if (sel == SEL_ONOFF && en1 && en2)
                m = FMODE_ONOFF;
        end
        return m;
    endfunction

endpackage

// File: rtl/rxm_match_cmp.sv
// Module rxm_match_cmp
// Compares one character against NUM_MATCH match values.
// Gives a raw equality per value and a hit qualified by that value's enable.
// Purely combinational; assumes all inputs are stable within the cycle.
module rxm_match_cmp #(
    parameter int DATA_W    = 8,
    parameter int NUM_MATCH = 2
) (
    input  logic [DATA_W-1:0]                 char_data,
    input  logic [NUM_MATCH-1:0][DATA_W-1:0]  match_vals,
    input  logic [NUM_MATCH-1:0]              match_ens,
    output logic [NUM_MATCH-1:0]              hit_raw,
    output logic [NUM_MATCH-1:0]              hit_en,
    output logic                              hit_any
);

    // One comparator per match value.
    for (genvar g = 0; g < NUM_MATCH; g++) begin : g_cmp
        assign hit_raw[g] = (char_data == match_vals[g]);
        assign hit_en[g]  = hit_raw[g] & match_ens[g];
    end

    // Any enabled hit.
    always_comb begin
        hit_any = |hit_en;
    end

endmodule

// File: rtl/rxm_window.sv
// Module rxm_window
// Holds the forwarding window for both schemes and decides, per character,
// whether it may be forwarded.
// Assumes idle_pulse is a single-cycle strobe. An idle pulse in the same cycle
// as a character is applied before that character is judged.
module rxm_window
    import rxm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  filt_mode_e mode,
    input  logic       char_vld,
    input  logic       idle_pulse,
    input  logic       hit_any,
    input  logic       hit_on,
    input  logic       hit_off,
    output logic       fwd_ok
);

    logic hunt_q;       // waiting for the first character after an idle line
    logic idle_open_q;  // idle-line window open
    logic onoff_open_q; // open/close window open
    logic hunt_eff;
    logic idle_open_eff;
    logic pass_now;

    // Apply an idle pulse that arrives with a character ahead of that character.
    always_comb begin
        hunt_eff      = hunt_q | idle_pulse;
        idle_open_eff = idle_pulse ? 1'b0 : idle_open_q;
    end

    // Per-character forward decision for the active scheme.
    always_comb begin
        unique case (mode)
            FMODE_IDLE:  pass_now = hunt_eff ? hit_any : idle_open_eff;
            FMODE_ONOFF: pass_now = onoff_open_q ? !hit_off : hit_on;
            default:     pass_now = 1'b1;
        endcase
        fwd_ok = char_vld & pass_now;
    end

    // Idle-line window: arm on idle, resolve on the first character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunt_q      <= 1'b0;
            idle_open_q <= 1'b0;
        end else if (char_vld) begin
            hunt_q <= 1'b0;
            if (hunt_eff)
                idle_open_q <= hit_any;
            else
                idle_open_q <= idle_open_eff;
        end else if (idle_pulse) begin
            hunt_q      <= 1'b1;
            idle_open_q <= 1'b0;
        end
    end

    // Open/close window: open on value 1, close on value 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            onoff_open_q <= 1'b0;
        end else if (char_vld && mode == FMODE_ONOFF) begin
            if (!onoff_open_q && hit_on)
                onoff_open_q <= 1'b1;
            else if (onoff_open_q && hit_off)
                onoff_open_q <= 1'b0;
        end
    end

    // R9
    reset_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!idle_open_q && !onoff_open_q && !hunt_q));

    // R4
    idle_miss_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FMODE_IDLE && char_vld && !fwd_ok) |=> !idle_open_q);

    // R3
    idle_hit_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FMODE_IDLE && char_vld && fwd_ok) |=> idle_open_q);

    // R8
    onoff_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FMODE_ONOFF && char_vld && onoff_open_q && hit_off) |=> !onoff_open_q);

    // R7
    onoff_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FMODE_ONOFF && char_vld && !onoff_open_q && hit_on) |=> onoff_open_q);

endmodule

// File: rtl/rxm_full_flag.sv
// Module rxm_full_flag
// Receive-data-full flag: set by a forwarded character, cleared by a pulse.
// Assumes set and clear are single-cycle strobes; set has priority.
module rxm_full_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic full
);

    // Flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full <= 1'b0;
        else if (set)
            full <= 1'b1;
        else if (clr)
            full <= 1'b0;
    end

    // R11
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> full);

    // R11
    full_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !full);

    // R11
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !set) |=> (full == $past(full)));

endmodule

// File: rtl/uart_rx_match_filter.sv
// Module uart_rx_match_filter
// Decides for each received UART character whether it goes to the receive
// buffer, using an idle-line address scheme or an open/close scheme.
// Outputs are registered: one cycle from character strobe to forward strobe.
// Assumes char_vld, idle_det and full_clr are single-cycle strobes.
module uart_rx_match_filter
    import rxm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_vld,
    input  logic [DATA_W-1:0] char_data,
    input  logic              idle_det,
    input  logic              match_en1,
    input  logic              match_en2,
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] match_val1,
    input  logic [DATA_W-1:0] match_val2,
    input  logic              full_clr,
    output logic              fwd_vld,
    output logic [DATA_W-1:0] fwd_data,
    output logic              rx_full
);

    localparam int NUM_MATCH = 2;

    filt_mode_e                        mode;
    logic [NUM_MATCH-1:0][DATA_W-1:0]  vals;
    logic [NUM_MATCH-1:0]              ens;
    logic [NUM_MATCH-1:0]              hit_raw;
    logic [NUM_MATCH-1:0]              hit_en;
    logic                              hit_any;
    logic                              fwd_ok;

    // Resolve the active scheme and pack the match values.
    always_comb begin
        mode    = decode_mode(match_en1, match_en2, mode_sel);
        vals[0] = match_val1;
        vals[1] = match_val2;
        ens     = {match_en2, match_en1};
    end

    rxm_match_cmp #(
        .DATA_W    (DATA_W),
        .NUM_MATCH (NUM_MATCH)
    ) i_cmp (
        .char_data  (char_data),
        .match_vals (vals),
        .match_ens  (ens),
        .hit_raw    (hit_raw),
        .hit_en     (hit_en),
        .hit_any    (hit_any)
    );

    rxm_window i_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .char_vld   (char_vld),
        .idle_pulse (idle_det),
        .hit_any    (hit_any),
        .hit_on     (hit_raw[0]),
        .hit_off    (hit_raw[1]),
        .fwd_ok     (fwd_ok)
    );

    rxm_full_flag i_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (fwd_ok),
        .clr   (full_clr),
        .full  (rx_full)
    );

    // Output register for the forwarded character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_vld  <= 1'b0;
            fwd_data <= '0;
        end else begin
            fwd_vld  <= fwd_ok;
            if (fwd_ok)
                fwd_data <= char_data;
        end
    end

    // R1
    pass_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld && !match_en1 && !match_en2)
        |=> (fwd_vld && fwd_data == $past(char_data)));

    // R1
    no_spurious_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |-> $past(char_vld));

    // R11
    full_with_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |-> rx_full);

    // R6
    either_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FMODE_IDLE && char_vld && idle_det && hit_en != '0) |=> fwd_vld);

endmodule

// File: tb/test_uart_rx_match_filter.sv
module test_uart_rx_match_filter;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              char_vld = 1'b0;
    logic [DATA_W-1:0] char_data = '0;
    logic              idle_det = 1'b0;
    logic              match_en1 = 1'b0;
    logic              match_en2 = 1'b0;
    logic [1:0]        mode_sel = 2'b00;
    logic [DATA_W-1:0] match_val1 = '0;
    logic [DATA_W-1:0] match_val2 = '0;
    logic              full_clr = 1'b0;
    logic              fwd_vld;
    logic [DATA_W-1:0] fwd_data;
    logic              rx_full;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_match_filter #(.DATA_W(DATA_W)) i_uart_rx_match_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .char_vld   (char_vld),
        .char_data  (char_data),
        .idle_det   (idle_det),
        .match_en1  (match_en1),
        .match_en2  (match_en2),
        .mode_sel   (mode_sel),
        .match_val1 (match_val1),
        .match_val2 (match_val2),
        .full_clr   (full_clr),
        .fwd_vld    (fwd_vld),
        .fwd_data   (fwd_data),
        .rx_full    (rx_full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(input bit e1, input bit e2, input logic [1:0] sel,
                       input logic [7:0] v1, input logic [7:0] v2);
        match_en1  = e1;
        match_en2  = e2;
        mode_sel   = sel;
        match_val1 = v1;
        match_val2 = v2;
    endtask

    task automatic idle();
        idle_det = 1'b1;
        @(negedge clk);
        idle_det = 1'b0;
    endtask

    // Send one character (optionally with idle and clear) and check the result.
    task automatic send(input logic [7:0] d, input bit with_idle, input bit clr,
                        input bit exp_fwd, input string req);
        char_vld  = 1'b1;
        char_data = d;
        idle_det  = with_idle;
        full_clr  = clr;
        @(negedge clk);
        char_vld = 1'b0;
        idle_det = 1'b0;
        full_clr = 1'b0;
        chk(fwd_vld == exp_fwd, req, fwd_vld, exp_fwd);
        if (exp_fwd)
            chk(fwd_data == d, req, fwd_data, d);
    endtask

    task automatic t_reset();
        chk(fwd_vld == 1'b0, "R9 reset fwd_vld", fwd_vld, 0);
        chk(rx_full == 1'b0, "R9 reset rx_full", rx_full, 0);
        // Idle-line scheme, no idle seen yet: window closed.
        cfg(1, 0, 2'b01, 8'h55, 8'h00);
        send(8'h55, 0, 0, 0, "R9 idle closed after reset");
        // Open/close scheme: closed until value 1.
        cfg(1, 1, 2'b10, 8'h5A, 8'hA5);
        send(8'h30, 0, 0, 0, "R9 onoff closed after reset");
    endtask

    task automatic t_pass();
        cfg(0, 0, 2'b01, 8'h11, 8'h22);
        send(8'h33, 0, 0, 1, "R1 enables low sel 01");
        cfg(0, 0, 2'b10, 8'h11, 8'h22);
        send(8'h44, 0, 0, 1, "R1 enables low sel 10");
        send(8'hFF, 0, 0, 1, "R1 enables low second char");
        cfg(1, 1, 2'b00, 8'h11, 8'h22);
        send(8'h01, 0, 0, 1, "R2 sel 00 passes");
        cfg(1, 1, 2'b11, 8'h11, 8'h22);
        send(8'h02, 0, 0, 1, "R2 sel 11 passes");
        cfg(1, 0, 2'b10, 8'h11, 8'h22);
        send(8'h03, 0, 0, 1, "R2 sel 10 single enable passes");
    endtask

    task automatic t_idle_hit();
        cfg(1, 0, 2'b01, 8'hA5, 8'h3C);
        idle();
        send(8'hA5, 0, 0, 1, "R3 address hit forwarded");
        send(8'h01, 0, 0, 1, "R3 data after hit");
        send(8'h02, 0, 0, 1, "R3 more data after hit");
        idle();
        send(8'h03, 0, 0, 0, "R4 new message miss");
    endtask

    task automatic t_idle_miss();
        cfg(1, 0, 2'b01, 8'hA5, 8'h3C);
        idle();
        send(8'h10, 0, 0, 0, "R4 first char miss");
        send(8'hA5, 0, 0, 0, "R4 later match still dropped");
    endtask

    task automatic t_single();
        cfg(1, 0, 2'b01, 8'hA5, 8'h3C);
        idle();
        send(8'h3C, 0, 0, 0, "R5 disabled value 2 ignored");
        cfg(0, 1, 2'b01, 8'hA5, 8'h3C);
        idle();
        send(8'hA5, 0, 0, 0, "R5 disabled value 1 ignored");
        idle();
        send(8'h3C, 0, 0, 1, "R5 own value 2 hits");
    endtask

    task automatic t_both();
        cfg(1, 1, 2'b01, 8'hA5, 8'h3C);
        idle();
        send(8'h3C, 0, 0, 1, "R6 value 2 opens");
        idle();
        send(8'hA5, 0, 0, 1, "R6 value 1 opens");
        send(8'h66, 0, 0, 1, "R6 data after value 1");
        idle();
        send(8'h77, 0, 0, 0, "R6 neither value dropped");
    endtask

    task automatic t_same_cycle();
        cfg(1, 0, 2'b01, 8'hA5, 8'h3C);
        idle();
        send(8'hA5, 0, 0, 1, "R10 open window");
        send(8'h44, 1, 0, 0, "R10 idle with char judged first");
        send(8'h45, 0, 0, 0, "R10 message stays dropped");
        send(8'hA5, 1, 0, 1, "R10 idle with matching char");
        send(8'h46, 0, 0, 1, "R10 window opened by it");
    endtask

    task automatic t_onoff();
        cfg(1, 1, 2'b10, 8'h5A, 8'hA5);
        send(8'h01, 0, 0, 0, "R7 closed drops");
        send(8'h5A, 0, 0, 1, "R7 value 1 forwarded");
        send(8'h02, 0, 0, 1, "R7 data while open");
        send(8'h5A, 0, 0, 1, "R7 value 1 while open");
        send(8'hA5, 0, 0, 0, "R8 value 2 dropped");
        send(8'h03, 0, 0, 0, "R8 closed after value 2");
        send(8'hA5, 0, 0, 0, "R8 value 2 while closed");
        send(8'h5A, 0, 0, 1, "R8 reopen on value 1");
        send(8'hA5, 0, 0, 0, "R8 close again");
    endtask

    task automatic t_flag();
        cfg(0, 0, 2'b00, 8'h00, 8'h00);
        send(8'h12, 0, 0, 1, "R11 forward");
        chk(rx_full == 1'b1, "R11 set with forward", rx_full, 1);
        full_clr = 1'b1;
        @(negedge clk);
        full_clr = 1'b0;
        chk(rx_full == 1'b0, "R11 cleared", rx_full, 0);
        cfg(1, 1, 2'b10, 8'h5A, 8'hA5);
        send(8'h07, 0, 0, 0, "R11 dropped char");
        chk(rx_full == 1'b0, "R11 drop keeps clear", rx_full, 0);
        send(8'h5A, 0, 1, 1, "R11 forward with clear");
        chk(rx_full == 1'b1, "R11 set wins", rx_full, 1);
        @(negedge clk);
        chk(rx_full == 1'b1, "R11 holds without clear", rx_full, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pass();
        t_idle_hit();
        t_idle_miss();
        t_single();
        t_both();
        t_same_cycle();
        t_onoff();
        t_flag();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule